// File: doc/BRIEF.md
# Keyboard Scan-Code Decoder

This block takes the bytes that a keyboard serial receiver has already assembled. Each byte arrives with a single-cycle valid strobe. The block turns the stream into key events.

Two prefix bytes are absorbed and never shown as events. One marks an extended key and the other marks a key release. Each prefix becomes a flag that is attached to the next real key code and is then cleared. The block follows the state of both shift keys. It also translates a small set of keys into ASCII, giving capital letters while either shift key is held.

Each result is held on the outputs until the consumer acknowledges it with a read pulse. A compile-time option can hide shift keys completely. With it set, the only sign of shift activity is the shift-status output.

Top module: `kbd_scan_decoder`

## Requirements
- R1: After reset, `ready_o`, `ext_o`, `rel_o` and `shift_on_o` are 0, and `code_o` and `ascii_o` are 0x00.
- R2: Byte 0xE0 is an extended prefix. It raises no event and leaves `ready_o` at 0. The next non-prefix byte is reported with `ext_o` = 1.
- R3: Byte 0xF0 is a release prefix. It raises no event and leaves `ready_o` at 0. The next non-prefix byte is reported with `rel_o` = 1. Both prefixes may come before one key, in either order.
- R4: `ext_o` and `rel_o` describe only the current key. Prefix flags are cleared by every non-prefix byte, including a shift key whose event is suppressed.
- R5: Left shift is code 0x12 and right shift is code 0x59. Without a release prefix, the code sets that key's held bit. With a release prefix, it clears that bit. `shift_on_o` is the OR of the two held bits and changes one cycle after the byte's valid cycle.
- R6: `ascii_o` follows a fixed mapping, and release events carry the same mapping as presses.
  - Letters a..z come from codes 1C 32 21 23 24 2B 34 33 43 3B 42 4B 3A 31 44 4D 15 2D 1B 2C 3C 2A 1D 22 35 1A. They give lower case (0x61 upward) and give upper case (0x41 upward) when shift was held before the byte.
  - Digits 0..9 come from codes 45 16 1E 26 25 2E 36 3D 3E 46 and give 0x30..0x39 whatever the shift state.
  - Code 0x29 gives 0x20, code 0x0D (tab) gives 0x09 and code 0x5A gives 0x0D.
  - Every other code gives 0x00.
- R7: With `TRAP_SHIFT` = 0, shift codes are presented like any other key. Their ASCII value is 0x00.
- R8: With `TRAP_SHIFT` = 1, a shift code presents no event: `ready_o` stays 0. It still updates `shift_on_o` and still clears the prefix flags.
- R9: A non-prefix byte loads `code_o`, `ascii_o`, `ext_o` and `rel_o`, and sets `ready_o` one cycle after its valid cycle. A one-cycle `read_i` pulse clears `ready_o` at the next edge. A new event in the same cycle as a read wins.
- R10: A new event that arrives while `ready_o` is still 1 overwrites the held result, and `ready_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_in | input | 8 | Received byte |
| byte_valid | input | 1 | One-cycle strobe marking `byte_in` valid |
| read_i | input | 1 | Consumer acknowledge of the held result |
| code_o | output | 8 | Scan code of the last event |
| ascii_o | output | 8 | ASCII value of the last event, 0x00 if unmapped |
| ext_o | output | 1 | Last event carried the extended prefix |
| rel_o | output | 1 | Last event was a key release |
| shift_on_o | output | 1 | Either shift key currently held |
| ready_o | output | 1 | A result is waiting to be read |

## Verification
Every result, including `shift_on_o`, is registered. It is due exactly one edge after the cycle in which the byte is valid, so the bench drives the strobe for one cycle from the falling edge and checks at the next falling edge. A read is given one full cycle, and the cleared `ready_o` is checked at the falling edge after that.

The bench sweeps all 254 non-prefix codes under four prefix patterns and both shift states. It runs a trapping instance next to a non-trapping one, and tracks the expected flags and shift bits arithmetically in its own model.

// File: rtl/kbd_scan_decoder.sv
module kbd_scan_decoder #(
  parameter bit         TRAP_SHIFT = 1'b0,
  parameter logic [7:0] EXT_PFX    = 8'hE0,
  parameter logic [7:0] REL_PFX    = 8'hF0,
  parameter logic [7:0] LSHIFT     = 8'h12,
  parameter logic [7:0] RSHIFT     = 8'h59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_in,
  input  logic       byte_valid,
  input  logic       read_i,
  output logic [7:0] code_o,
  output logic [7:0] ascii_o,
  output logic       ext_o,
  output logic       rel_o,
  output logic       shift_on_o,
  output logic       ready_o
);

  logic hold_ext, hold_rel, lsh, rsh;

  wire pfx_e    = byte_valid && (byte_in == EXT_PFX);
  wire pfx_r    = byte_valid && (byte_in == REL_PFX);
  wire key_evt  = byte_valid && !(byte_in == EXT_PFX) && !(byte_in == REL_PFX);
  wire is_shift = (byte_in == LSHIFT) || (byte_in == RSHIFT);
  wire strobe   = key_evt && !(TRAP_SHIFT && is_shift);

  assign shift_on_o = lsh | rsh;

  function automatic logic [7:0] to_ascii(input logic [7:0] c, input logic up);
    logic [7:0] a;
    case (c)
      8'h1C: a = "a";  8'h32: a = "b";  8'h21: a = "c";  8'h23: a = "d";
      8'h24: a = "e";  8'h2B: a = "f";  8'h34: a = "g";  8'h33: a = "h";
      8'h43: a = "i";  8'h3B: a = "j";  8'h42: a = "k";  8'h4B: a = "l";
      8'h3A: a = "m";  8'h31: a = "n";  8'h44: a = "o";  8'h4D: a = "p";
      8'h15: a = "q";  8'h2D: a = "r";  8'h1B: a = "s";  8'h2C: a = "t";
      8'h3C: a = "u";  8'h2A: a = "v";  8'h1D: a = "w";  8'h22: a = "x";
      8'h35: a = "y";  8'h1A: a = "z";
      8'h45: a = "0";  8'h16: a = "1";  8'h1E: a = "2";  8'h26: a = "3";
      8'h25: a = "4";  8'h2E: a = "5";  8'h36: a = "6";  8'h3D: a = "7";
      8'h3E: a = "8";  8'h46: a = "9";
      8'h29: a = 8'h20;
      8'h0D: a = 8'h09;
      8'h5A: a = 8'h0D;
      default: a = 8'h00;
    endcase
    if (up && a >= "a" && a <= "z") a = a - 8'h20;
    return a;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_ext <= 1'b0;
      hold_rel <= 1'b0;
      lsh      <= 1'b0;
      rsh      <= 1'b0;
      code_o   <= 8'h00;
      ascii_o  <= 8'h00;
      ext_o    <= 1'b0;
      rel_o    <= 1'b0;
      ready_o  <= 1'b0;
    end else begin
      if (pfx_e) hold_ext <= 1'b1;
      if (pfx_r) hold_rel <= 1'b1;
      if (key_evt) begin
        hold_ext <= 1'b0;
        hold_rel <= 1'b0;
        if (byte_in == LSHIFT) lsh <= !hold_rel;
        if (byte_in == RSHIFT) rsh <= !hold_rel;
      end
      if (strobe) begin
        code_o  <= byte_in;
        ascii_o <= to_ascii(byte_in, lsh | rsh);
        ext_o   <= hold_ext;
        rel_o   <= hold_rel;
        ready_o <= 1'b1;
      end else if (read_i) begin
        ready_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/kbd_scan_decoder_chk.sv
module kbd_scan_decoder_chk #(
  parameter bit TRAP_SHIFT = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] byte_in,
  input logic       byte_valid,
  input logic       read_i,
  input logic [7:0] code_o,
  input logic       shift_on_o,
  input logic       ready_o
);

  assert_ready_after_byte_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(byte_valid));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (read_i && !byte_valid) |=> !ready_o);

  assert_prefix_no_event_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && (byte_in == 8'hE0 || byte_in == 8'hF0)) |=> ($stable(code_o) && !$rose(ready_o)));

  assert_shift_only_on_byte_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(shift_on_o) |-> $past(byte_valid));

  assert_trap_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (TRAP_SHIFT && byte_valid && (byte_in == 8'h12 || byte_in == 8'h59)) |=> !$rose(ready_o));

endmodule

bind kbd_scan_decoder kbd_scan_decoder_chk #(.TRAP_SHIFT(TRAP_SHIFT)) u_chk (
  .clk(clk), .rst(rst), .byte_in(byte_in), .byte_valid(byte_valid),
  .read_i(read_i), .code_o(code_o), .shift_on_o(shift_on_o), .ready_o(ready_o));

// File: tb/tb_kbd_scan_decoder.sv
`timescale 1ns/1ps
module tb_kbd_scan_decoder;
  logic clk = 0, rst = 1, byte_valid = 0, read_i = 0;
  logic [7:0] byte_in = 8'h00;
  logic [7:0] code_a, ascii_a, code_b, ascii_b;
  logic ext_a, rel_a, sh_a, rdy_a, ext_b, rel_b, sh_b, rdy_b;
  int checks = 0, fails = 0;
  bit hext = 0, hrel = 0, lsh = 0, rsh = 0;

  always #5 clk = ~clk;

  kbd_scan_decoder #(.TRAP_SHIFT(1'b0)) dut (.clk(clk), .rst(rst), .byte_in(byte_in),
    .byte_valid(byte_valid), .read_i(read_i), .code_o(code_a), .ascii_o(ascii_a),
    .ext_o(ext_a), .rel_o(rel_a), .shift_on_o(sh_a), .ready_o(rdy_a));
  kbd_scan_decoder #(.TRAP_SHIFT(1'b1)) dut_t (.clk(clk), .rst(rst), .byte_in(byte_in),
    .byte_valid(byte_valid), .read_i(read_i), .code_o(code_b), .ascii_o(ascii_b),
    .ext_o(ext_b), .rel_o(rel_b), .shift_on_o(sh_b), .ready_o(rdy_b));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_ascii(int c, bit up);
    string lt = "azbcdefghijklmnopqrstuvwxyz";
    int lc[26] = '{'h1C,'h32,'h21,'h23,'h24,'h2B,'h34,'h33,'h43,'h3B,'h42,'h4B,'h3A,
                   'h31,'h44,'h4D,'h15,'h2D,'h1B,'h2C,'h3C,'h2A,'h1D,'h22,'h35,'h1A};
    int dc[10] = '{'h45,'h16,'h1E,'h26,'h25,'h2E,'h36,'h3D,'h3E,'h46};
    for (int i = 0; i < 26; i++) if (lc[i] == c) return (up ? 'h41 : 'h61) + i;
    for (int i = 0; i < 10; i++) if (dc[i] == c) return 'h30 + i;
    if (c == 'h29) return 'h20;
    if (c == 'h0D) return 'h09;
    if (c == 'h5A) return 'h0D;
    return 0;
  endfunction

  task automatic drive(int b);
    @(negedge clk); byte_in = b[7:0]; byte_valid = 1;
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic do_read();
    @(negedge clk); read_i = 1;
    @(negedge clk); read_i = 0;
    chk("R9 ready cleared by read", rdy_a, 0);
    chk("R9 ready cleared by read (trap)", rdy_b, 0);
  endtask

  task automatic send_pfx(int b);
    if (b == 'hE0) hext = 1; else hrel = 1;
    drive(b);
    chk("R2/R3 prefix raises no event", rdy_a, 0);
    chk("R2/R3 prefix raises no event (trap)", rdy_b, 0);
  endtask

  task automatic send_key(int c);
    int ea; bit e, r, shk;
    ea = ref_ascii(c, lsh | rsh);
    e = hext; r = hrel;
    shk = (c == 'h12 || c == 'h59);
    if (c == 'h12) lsh = !r;
    if (c == 'h59) rsh = !r;
    hext = 0; hrel = 0;
    drive(c);
    chk("R9 code", code_a, c);
    chk("R6 ascii", ascii_a, ea);
    chk("R2 ext flag", ext_a, e);
    chk("R3 rel flag", rel_a, r);
    chk("R9 ready set", rdy_a, 1);
    chk("R5 shift status", sh_a, lsh | rsh);
    chk("R5 shift status (trap)", sh_b, lsh | rsh);
    if (shk) begin
      chk("R7 shift passed, no ascii", ascii_a, 0);
      chk("R8 trapped shift silent", rdy_b, 0);
    end else begin
      chk("R8 trap passes key code", code_b, c);
      chk("R6 ascii (trap)", ascii_b, ea);
      chk("R4 ext flag (trap)", ext_b, e);
      chk("R4 rel flag (trap)", rel_b, r);
      chk("R9 ready set (trap)", rdy_b, 1);
    end
    do_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ready", rdy_a, 0); chk("R1 code", code_a, 0); chk("R1 ascii", ascii_a, 0);
    chk("R1 ext", ext_a, 0); chk("R1 rel", rel_a, 0); chk("R1 shift", sh_a, 0);
    chk("R1 ready (trap)", rdy_b, 0);

    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 4; p++)
        for (int c = 0; c < 256; c++) begin
          if (c == 'hE0 || c == 'hF0) continue;
          if (s == 1 && !(lsh | rsh)) send_key('h12);
          if (s == 0 && (lsh | rsh)) begin
            send_pfx('hF0); send_key('h12);
            send_pfx('hF0); send_key('h59);
          end
          if (p == 3) begin send_pfx('hF0); send_pfx('hE0); end
          else begin
            if (p[0]) send_pfx('hE0);
            if (p[1]) send_pfx('hF0);
          end
          send_key(c);
        end

    // R4: trapped shift key still clears held prefix flags
    send_pfx('hE0);
    send_key('h59);
    send_key('h1C);
    chk("R4 trap cleared ext", ext_b, 0);
    // R10: overwrite without read
    drive('h1C);
    drive('h32);
    chk("R10 ready held", rdy_a, 1);
    chk("R10 overwritten code", code_a, 'h32);
    chk("R10 overwritten ascii", ascii_a, ref_ascii('h32, lsh | rsh));
    do_read();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule